// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block sits on a 32-bit word bus and holds two transmit frame buffers. Each buffer has its own length word and control word, which sit at the top of that buffer's window. Software fills a buffer with frame bytes, writes the byte count and then writes the control word. The control word starts one of two actions. The first sends the buffered bytes out on a byte stream that uses valid, last and ready handshakes. The second copies the first six buffer bytes into a 48-bit station address register.

Start and Program read back as 1 while an action is pending or running. Both clear by themselves when the action ends. A one-cycle interrupt pulse marks completion when the control word's interrupt-enable bit is set and the single global enable bit is also set. Actions never overlap. When both buffers wait to be served, buffer 0 goes first.

Addresses are byte addresses within an 8 KiB window. The lower 4 KiB holds the two transmit buffers, buffer 0 at 0x0000 and buffer 1 at 0x0800. The upper 4 KiB is not implemented.

Top module: `txfb_top`

## Requirements
- R1: A read with `bus_rd` high delivers its data on `bus_rdata` in the next cycle only, with 0 there otherwise; a buffer data word reads back the value last written to it.
- R2: The length word is at byte 0x7F4 for buffer 0 and 0xFF4 for buffer 1 and keeps its low 11 bits (upper bits read 0). The global enable at 0x7F8 keeps only bit 31. Byte 0xFF8 is ordinary buffer-1 storage.
- R3: An access whose address has bits [1:0] not zero, or bit 12 set, is dropped: a write changes nothing and a read returns 0.
- R4: In the control word, bit 0 is Start, bit 1 is Program and bit 3 is interrupt-enable. Writing Start=1 with Program=0 streams `len` bytes of that buffer on `tx_data`. Byte k is bits [8*(k%4)+7 : 8*(k%4)] of word k/4. `tx_last` is high only with byte len-1.
- R5: Writing Start=1 with Program=1 sets `station_addr[8i+7:8i]` to buffer byte i, for i = 0 to 5, and streams no bytes. `station_addr` resets to 0.
- R6: Start and Program read 1 from the control write until the action ends, then read 0. The other written bits are kept. A write with Start=0 begins no action and reads back with bits 1:0 clear.
- R7: A write to a control word whose Start bit is still set is ignored entirely.
- R8: At completion, `irq` is high for exactly one cycle if and only if the control word's bit 3 and the global enable's bit 31 are both 1.
- R9: One action runs at a time. A buffer started while the other one's action is in progress is served after that action ends. When both are pending, buffer 0 is served first.
- R10: A transmit with length 0 streams no bytes and completes normally, including the interrupt rule.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Completion pulse |
| station_addr | output | 48 | Station address register |

## Verification
The hardest case to reach is a second control write that lands while an action is still running. Both the ignored same-buffer restart and the queued other-buffer start depend on it. Since the bus carries one write per cycle, the bench makes this window by holding `tx_ready` low. That stalls a frame, and the bench then issues the conflicting writes and reads back the control words before it releases the stream. The rest of the run uses frames of random length from random buffers, with random backpressure. The received bytes are compared against a shadow copy of the buffers.

// File: rtl/txfb_pkg.sv
package txfb_pkg;
   typedef enum logic [1:0] {K_DATA, K_LEN, K_GIE, K_CTRL} reg_kind_e;
   typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_CAP, ST_SEND, ST_DONE} eng_state_e;
   localparam int BIT_START = 0;
   localparam int BIT_PROG  = 1;
   localparam int BIT_IE    = 3;
   localparam int BIT_GIE   = 31;
   // word offsets counted down from the top of a buffer window
   localparam int OFS_CTRL  = 1;
   localparam int OFS_GIE   = 2;
   localparam int OFS_LEN   = 3;
endpackage

// File: rtl/txfb_decode.sv
module txfb_decode
   import txfb_pkg::*;
#(
   parameter int WIDX_W = 9,
   localparam int ADDR_W = WIDX_W + 4,
   localparam int BUF_WORDS = 1 << WIDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              buf_sel,
   output logic [WIDX_W-1:0] widx,
   output reg_kind_e         kind
);
   logic aligned, upper_half;

   assign aligned    = (addr[1:0] == 2'b00);
   assign upper_half = addr[ADDR_W-1];
   assign hit        = aligned && !upper_half;
   assign buf_sel    = addr[ADDR_W-2];
   assign widx       = addr[ADDR_W-3:2];

   always_comb begin
      kind = K_DATA;
      if (widx == WIDX_W'(BUF_WORDS - OFS_CTRL))
         kind = K_CTRL;
      else if (widx == WIDX_W'(BUF_WORDS - OFS_LEN))
         kind = K_LEN;
      else if (widx == WIDX_W'(BUF_WORDS - OFS_GIE) && !buf_sel)
         kind = K_GIE;
   end
endmodule

// File: rtl/txfb_ram.sv
module txfb_ram #(
   parameter int AW = 10,
   parameter int DW = 32,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [DW-1:0] ra_q,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] rb_q
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      ra_q <= mem[ra_addr];
      rb_q <= mem[rb_addr];
   end
endmodule

// File: rtl/txfb_regs.sv
module txfb_regs
   import txfb_pkg::*;
#(
   parameter int NUM_BUF = 2,
   parameter int LEN_W   = 11,
   localparam int SEL_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_buf,
   input  reg_kind_e                       wr_kind,
   input  logic [31:0]                     wdata,
   input  logic                            done,
   input  logic [SEL_W-1:0]                done_buf,
   output logic [NUM_BUF-1:0][LEN_W-1:0]   len,
   output logic [NUM_BUF-1:0][31:0]        ctrl_word,
   output logic [NUM_BUF-1:0]              start,
   output logic [NUM_BUF-1:0]              prog,
   output logic [NUM_BUF-1:0]              ie,
   output logic                            gie
);
   logic [NUM_BUF-1:0] wsel, dsel;

   assign wsel = wr_en ? (NUM_BUF'(1) << wr_buf) : '0;
   assign dsel = done  ? (NUM_BUF'(1) << done_buf) : '0;

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      logic [31:2] keep;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            len[b]   <= '0;
            keep     <= '0;
            start[b] <= 1'b0;
            prog[b]  <= 1'b0;
         end else begin
            if (wsel[b] && wr_kind == K_LEN)
               len[b] <= wdata[LEN_W-1:0];
            if (dsel[b]) begin
               start[b] <= 1'b0;
               prog[b]  <= 1'b0;
            end else if (wsel[b] && wr_kind == K_CTRL && !start[b]) begin
               keep     <= wdata[31:2];
               start[b] <= wdata[BIT_START];
               prog[b]  <= wdata[BIT_START] & wdata[BIT_PROG];
            end
         end
      end

      assign ctrl_word[b] = {keep, prog[b], start[b]};
      assign ie[b]        = keep[BIT_IE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         gie <= 1'b0;
      else if (wsel[0] && wr_kind == K_GIE)
         gie <= wdata[BIT_GIE];
   end
endmodule

// File: rtl/txfb_engine.sv
module txfb_engine
   import txfb_pkg::*;
#(
   parameter int NUM_BUF   = 2,
   parameter int LEN_W     = 11,
   parameter bit LSB_FIRST = 1'b1,
   localparam int SEL_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int WIDX_W   = LEN_W - 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BUF-1:0]            start,
   input  logic [NUM_BUF-1:0]            prog,
   input  logic [NUM_BUF-1:0][LEN_W-1:0] len,
   input  logic [NUM_BUF-1:0]            ie,
   input  logic                          gie,
   output logic [SEL_W+WIDX_W-1:0]       ram_addr,
   input  logic [31:0]                   ram_q,
   output logic [7:0]                    tx_data,
   output logic                          tx_valid,
   output logic                          tx_last,
   input  logic                          tx_ready,
   output logic                          done,
   output logic [SEL_W-1:0]              done_buf,
   output logic                          irq,
   output logic [47:0]                   station_addr
);
   eng_state_e       state;
   logic [SEL_W-1:0] sel, pick;
   logic             is_prog;
   logic [LEN_W-1:0] len_r, cnt;
   logic [31:0]      word_r, addr_lo;
   logic [1:0]       lane;
   logic             last_byte;

   // lowest index wins
   always_comb begin
      pick = '0;
      for (int i = NUM_BUF - 1; i >= 0; i--)
         if (start[i]) pick = SEL_W'(i);
   end

   assign lane      = cnt[1:0];
   assign last_byte = (cnt == len_r - LEN_W'(1));
   assign ram_addr  = {sel, cnt[LEN_W-1:2]};
   assign tx_valid  = (state == ST_SEND);
   assign tx_last   = tx_valid && last_byte;
   assign done      = (state == ST_DONE);
   assign done_buf  = sel;

   if (LSB_FIRST) begin : g_lsb
      assign tx_data = word_r[{lane, 3'b000} +: 8];
   end else begin : g_msb
      assign tx_data = word_r[{~lane, 3'b000} +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         sel          <= '0;
         is_prog      <= 1'b0;
         len_r        <= '0;
         cnt          <= '0;
         word_r       <= '0;
         addr_lo      <= '0;
         station_addr <= '0;
         irq          <= 1'b0;
      end else begin
         irq <= done && ie[sel] && gie;
         unique case (state)
            ST_IDLE: if (|start) begin
               sel     <= pick;
               is_prog <= prog[pick];
               len_r   <= len[pick];
               cnt     <= '0;
               state   <= (!prog[pick] && len[pick] == '0) ? ST_DONE : ST_LOAD;
            end
            ST_LOAD: state <= ST_CAP;
            ST_CAP: begin
               if (is_prog) begin
                  if (cnt == '0) begin
                     addr_lo <= ram_q;
                     cnt     <= LEN_W'(4);
                     state   <= ST_LOAD;
                  end else begin
                     station_addr <= {ram_q[15:0], addr_lo};
                     state        <= ST_DONE;
                  end
               end else begin
                  word_r <= ram_q;
                  state  <= ST_SEND;
               end
            end
            ST_SEND: if (tx_ready) begin
               if (last_byte) begin
                  state <= ST_DONE;
               end else begin
                  cnt <= cnt + LEN_W'(1);
                  if (lane == 2'd3) state <= ST_LOAD;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txfb_top.sv
module txfb_top
   import txfb_pkg::*;
#(
   parameter int BUF_BYTES = 2048,
   parameter bit LSB_FIRST = 1'b1,
   localparam int NUM_BUF   = 2,
   localparam int BUF_WORDS = BUF_BYTES / 4,
   localparam int WIDX_W    = $clog2(BUF_WORDS),
   localparam int LEN_W     = $clog2(BUF_BYTES),
   localparam int ADDR_W    = LEN_W + 2,
   localparam int RAM_AW    = WIDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              irq,
   output logic [47:0]       station_addr
);
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES < 16) begin : g_bad_size
      $error("BUF_BYTES must be a power of two of at least 16");
   end

   logic              hit, dec_buf;
   logic [WIDX_W-1:0] widx;
   reg_kind_e         kind;
   logic [NUM_BUF-1:0][LEN_W-1:0] len;
   logic [NUM_BUF-1:0][31:0]      ctrl_word;
   logic [NUM_BUF-1:0] start, prog, ie;
   logic              gie, done, done_buf;
   logic [RAM_AW-1:0] eng_addr;
   logic [31:0]       ram_a_q, ram_b_q, reg_val, reg_q;
   logic              use_ram_q;

   txfb_decode #(.WIDX_W(WIDX_W)) u_dec (
      .addr(bus_addr), .hit(hit), .buf_sel(dec_buf), .widx(widx), .kind(kind));

   txfb_regs #(.NUM_BUF(NUM_BUF), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit), .wr_buf(dec_buf),
      .wr_kind(kind), .wdata(bus_wdata), .done(done), .done_buf(done_buf),
      .len(len), .ctrl_word(ctrl_word), .start(start), .prog(prog),
      .ie(ie), .gie(gie));

   txfb_ram #(.AW(RAM_AW), .DW(32)) u_ram (
      .clk(clk), .we(bus_wr && hit), .waddr({dec_buf, widx}), .wdata(bus_wdata),
      .ra_addr({dec_buf, widx}), .ra_q(ram_a_q),
      .rb_addr(eng_addr), .rb_q(ram_b_q));

   txfb_engine #(.NUM_BUF(NUM_BUF), .LEN_W(LEN_W), .LSB_FIRST(LSB_FIRST)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .prog(prog), .len(len),
      .ie(ie), .gie(gie), .ram_addr(eng_addr), .ram_q(ram_b_q),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_ready(tx_ready), .done(done), .done_buf(done_buf), .irq(irq),
      .station_addr(station_addr));

   always_comb begin
      unique case (kind)
         K_LEN:   reg_val = 32'(len[dec_buf]);
         K_GIE:   reg_val = {gie, 31'b0};
         K_CTRL:  reg_val = ctrl_word[dec_buf];
         default: reg_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_ram_q <= 1'b0;
         reg_q     <= '0;
      end else begin
         use_ram_q <= bus_rd && hit && kind == K_DATA;
         reg_q     <= (bus_rd && hit && kind != K_DATA) ? reg_val : '0;
      end
   end

   assign bus_rdata = use_ram_q ? ram_a_q : reg_q;
endmodule

// File: rtl/txfb_chk.sv
module txfb_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [7:0]        tx_data,
   input logic              tx_valid,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              irq,
   input logic [47:0]       station_addr
);
   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);                                              // R4
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R11
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);                                                      // R8
   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1]) |=> bus_rdata == 32'h0); // R3
   AST_STATION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $stable(station_addr));                                // R5
endmodule

bind txfb_top txfb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_txfb_top.sv
module sim_txfb_top;
   localparam int AW = 13;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0, tx_ready = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [7:0] tx_data;
   logic tx_valid, tx_last, irq;
   logic [47:0] station_addr;

   int n_chk = 0, n_bad = 0;
   int rdy_mode = 0;
   int cap_n = 0, irq_cnt = 0, irq_wide = 0, hold_err = 0;
   logic [7:0] cap [0:4095];
   logic capl [0:4095];
   logic [31:0] sh [0:1023];
   logic irq_prev = 1'b0, pv = 1'b0, pr = 1'b0;
   logic [7:0] pd = '0;
   logic gie_b = 1'b0;

   txfb_top u0 (.*);

   always #4 clk = ~clk;

   always @(posedge clk) begin
      #1;
      case (rdy_mode)
         0: tx_ready = 1'b1;
         1: tx_ready = 1'($urandom % 2);
         default: tx_ready = 1'b0;
      endcase
   end

   always @(negedge clk) if (rst_n) begin
      if (tx_valid && tx_ready) begin
         cap[cap_n] = tx_data; capl[cap_n] = tx_last; cap_n++;
      end
      if (irq) irq_cnt++;
      if (irq && irq_prev) irq_wide++;
      irq_prev = irq;
      if (pv && !pr && (!tx_valid || tx_data != pd)) hold_err++;
      pv = tx_valid; pr = tx_ready; pd = tx_data;
   end

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   function automatic int ctrl_a(input int b); return b * 'h800 + 'h7FC; endfunction
   function automatic int len_a(input int b);  return b * 'h800 + 'h7F4; endfunction

   function automatic logic [7:0] exp_byte(input int b, input int k);
      logic [31:0] w = sh[b * 512 + k / 4];
      return 8'(w >> (8 * (k % 4)));
   endfunction

   task automatic fill(input int b, input int len);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] d = $urandom;
         wr(b * 'h800 + 4 * w, d);
         sh[b * 512 + w] = d;
      end
      wr(len_a(b), 32'(len));
   endtask

   task automatic wait_idle(input int b);
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(ctrl_a(b), v);
         if (!v[0]) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_bytes(input int b, input int base, input int len);
      for (int k = 0; k < len; k++) begin
         check(cap[base + k] == exp_byte(b, k), "R4 byte", 64'(cap[base + k]), 64'(exp_byte(b, k)));
         check(capl[base + k] == (k == len - 1), "R4 last flag", 64'(capl[base + k]), 64'(k == len - 1));
      end
   endtask

   task automatic send_frame(input int b, input int len, input logic [31:0] ctrl, input int mode, input string tag);
      int base, i0;
      fill(b, len);
      rdy_mode = mode; base = cap_n; i0 = irq_cnt;
      wr(ctrl_a(b), ctrl | 32'h1);
      wait_idle(b);
      rdy_mode = 0;
      check(cap_n - base == len, tag, 64'(cap_n - base), 64'(len));
      check_bytes(b, base, len);
      check(irq_cnt - i0 == int'(ctrl[3] && gie_b), "R8 irq count", 64'(irq_cnt - i0), 64'(ctrl[3] && gie_b));
   endtask

   initial begin
      logic [31:0] v;
      int b0, i0;
      void'($urandom(32'h1F2E3D4C));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(tx_valid == 1'b0, "R4 reset valid", 64'(tx_valid), 0);
      check(irq == 1'b0, "R8 reset irq", 64'(irq), 0);
      check(station_addr == '0, "R5 reset station", 64'(station_addr), 0);
      rd(ctrl_a(0), v); check(v == 0, "R6 reset ctrl", 64'(v), 0);
      rd(len_a(1), v);  check(v == 0, "R2 reset len", 64'(v), 0);

      // R1 readback, directed and random
      wr('h000, 32'hA5A55A5A); wr('h87C, 32'h0BADF00D);
      rd('h000, v); check(v == 32'hA5A55A5A, "R1 buf0 word0", 64'(v), 64'hA5A55A5A);
      rd('h87C, v); check(v == 32'h0BADF00D, "R1 buf1 word31", 64'(v), 64'h0BADF00D);
      @(negedge clk); check(bus_rdata == 0, "R1 idle rdata", 64'(bus_rdata), 0);
      for (int i = 0; i < 10; i++) begin
         int a = int'($urandom % 2) * 'h800 + int'($urandom % 509) * 4;
         logic [31:0] d = $urandom;
         wr(a, d); rd(a, v);
         check(v == d, "R1 random word", 64'(v), 64'(d));
      end

      // R2 register widths
      wr(len_a(0), 32'hFFFFFFFF); rd(len_a(0), v); check(v == 32'h7FF, "R2 len width", 64'(v), 64'h7FF);
      wr('h7F8, 32'hFFFFFFFF); rd('h7F8, v); check(v == 32'h80000000, "R2 gie width", 64'(v), 64'h80000000);
      wr('hFF8, 32'h12345678); rd('hFF8, v); check(v == 32'h12345678, "R2 buf1 storage", 64'(v), 64'h12345678);

      // R3 dropped accesses
      wr('h002, 32'hFFFFFFFF); rd('h000, v); check(v == 32'hA5A55A5A, "R3 misaligned write", 64'(v), 64'hA5A55A5A);
      rd('h002, v); check(v == 0, "R3 misaligned read", 64'(v), 0);
      wr('h1000, 32'h55555555); rd('h1000, v); check(v == 0, "R3 upper read", 64'(v), 0);
      rd('h000, v); check(v == 32'hA5A55A5A, "R3 upper write alias", 64'(v), 64'hA5A55A5A);

      // R4 / R8 directed and random frames
      wr('h7F8, 32'h80000000); gie_b = 1'b1;
      send_frame(0, 1, 32'h8, 0, "R4 count len1");
      send_frame(1, 4, 32'h8, 0, "R4 count len4");
      send_frame(0, 5, 32'h8, 1, "R4 count len5");
      for (int i = 0; i < 8; i++)
         send_frame(int'($urandom % 2), 1 + int'($urandom % 40), ($urandom % 2) ? 32'h8 : 32'h0, 1, "R4 count random");

      // R8 gating
      wr('h7F8, 32'h0); gie_b = 1'b0;
      send_frame(1, 6, 32'h8, 0, "R8 no gie");
      wr('h7F8, 32'h80000000); gie_b = 1'b1;
      send_frame(0, 3, 32'h0, 0, "R8 no ie");

      // R10 zero length
      send_frame(1, 0, 32'h8, 0, "R10 zero length");
      rd(ctrl_a(1), v); check(v == 32'h8, "R10 start cleared", 64'(v), 64'h8);

      // R6 / R7 busy readback and ignored restart
      fill(0, 8);
      rdy_mode = 2; b0 = cap_n; i0 = irq_cnt;
      wr(ctrl_a(0), 32'h109);
      rd(ctrl_a(0), v); check(v == 32'h109, "R6 busy readback", 64'(v), 64'h109);
      wr(ctrl_a(0), 32'h3);
      rd(ctrl_a(0), v); check(v == 32'h109, "R7 write ignored", 64'(v), 64'h109);
      rdy_mode = 0;
      wait_idle(0);
      repeat (20) @(negedge clk);
      rd(ctrl_a(0), v); check(v == 32'h108, "R6 done readback", 64'(v), 64'h108);
      check(cap_n - b0 == 8, "R7 single frame", 64'(cap_n - b0), 8);
      check_bytes(0, b0, 8);
      check(irq_cnt - i0 == 1, "R7 single irq", 64'(irq_cnt - i0), 1);

      // R6 Start=0 write: no action
      b0 = cap_n; i0 = irq_cnt;
      wr(ctrl_a(1), 32'h10A);
      repeat (10) @(negedge clk);
      rd(ctrl_a(1), v); check(v == 32'h108, "R6 no-start write", 64'(v), 64'h108);
      check(cap_n == b0 && irq_cnt == i0, "R6 no action", 64'(cap_n - b0), 0);

      // R9 queued start on the other buffer
      rdy_mode = 2;
      fill(1, 3);
      wr(ctrl_a(1), 32'h9);
      fill(0, 2);
      b0 = cap_n; i0 = irq_cnt;
      wr(ctrl_a(0), 32'h9);
      rdy_mode = 0;
      wait_idle(1); wait_idle(0);
      check(cap_n - b0 == 5, "R9 total bytes", 64'(cap_n - b0), 5);
      check_bytes(1, b0, 3);
      check_bytes(0, b0 + 3, 2);
      check(irq_cnt - i0 == 2, "R9 two irqs", 64'(irq_cnt - i0), 2);

      // R5 station address load
      wr('h800, 32'h44332211); wr('h804, 32'hBBAA6655);
      b0 = cap_n; i0 = irq_cnt;
      wr(ctrl_a(1), 32'hB);
      wait_idle(1);
      check(station_addr == 48'h665544332211, "R5 station", 64'(station_addr), 64'h665544332211);
      check(cap_n == b0, "R5 no bytes", 64'(cap_n - b0), 0);
      check(irq_cnt - i0 == 1, "R8 program irq", 64'(irq_cnt - i0), 1);
      rd(ctrl_a(1), v); check(v == 32'h8, "R6 program cleared", 64'(v), 64'h8);

      // R11 / R8 handshake and pulse width over the whole run
      check(hold_err == 0, "R11 stall hold", 64'(hold_err), 0);
      check(irq_wide == 0, "R8 pulse width", 64'(irq_wide), 0);

      report();
   end
endmodule